// File: doc/BRIEF.md
# Vector Issue Interlock

This block sits between instruction decode and a vector execute pipeline. It decides, cycle by cycle, whether the candidate instruction at its input may enter the pipeline. The alternative is to hold the candidate and insert a bubble. The block keeps a shadow of the execute stages: dependency check, two shuffle/convert stages, four arithmetic stages and write-back. Each stage holds the destination register and pipeline class of its occupant. No arithmetic is performed here. Only timing is modelled.

The candidate is offered on a valid/ready handshake. `in_ready` reflects the payload that is currently presented, and `issue` marks the cycle in which the instruction is accepted. Once `in_valid` is raised, the payload must stay stable until `issue`. While the candidate is held, `stall` is high, and each clock pushes an empty slot into the first stage. An instruction whose sources match no destination in flight is accepted at once, whatever else is in flight.

A dependence needs a number of wait cycles, which depends on where the consumer needs the data:
- A normal arithmetic forward into the first arithmetic stage costs 3.
- A forward into the first shuffle stage, for a swizzled operand or a table lookup, costs 5.
- A wait for write-back when producer and consumer lie in different pipeline families costs 7.

Top module: `vec_issue_interlock`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties every stage: `stage_occ` reads 0 and `stall` is low after reset.
- R2: When no source of the candidate matches an occupied stage's destination, `in_ready` is high and `issue` equals `in_valid`. Back-to-back independent instructions issue on consecutive cycles.
- R3: A single-precision (class 0) or transcendental (class 2) producer followed by a single-precision consumer reading it through an unswizzled source waits 3 bubbles when presented right after the producer.
- R4: When the matching source is source B and `in_swz` is high, a same-family dependence waits 5 bubbles.
- R5: A transcendental consumer (class 2) of a single-precision-family producer waits 5 bubbles.
- R6: When exactly one of producer and consumer is double precision (class 1), the dependence waits 7 bubbles. No stall run is longer than 7 cycles.
- R7: A double-precision consumer of a double-precision producer waits 3 bubbles, or 5 if source B matches and is swizzled.
- R8: The wait is reduced by one for each stage the producer has already advanced past the first. Across all producers in flight, the largest remaining wait applies.
- R9: An issued instruction appears in `stage_occ[0]` one cycle later and advances one stage per cycle. It leaves after the last stage (bit 7). A held cycle inserts a 0 into bit 0.
- R10: While the candidate is held, `in_ready` is low, `stall` is high and `issue` is low.
- R11: `in_swz` affects only source B. A match on source A alone with `in_swz` high costs the unswizzled wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Candidate instruction present |
| in_ready | output | 1 | Candidate may enter this cycle |
| in_class | input | 2 | 0 single precision, 1 double precision, 2 transcendental |
| in_swz | input | 1 | Source B is swizzled |
| in_dst | input | REG_W | Destination register |
| in_src_a | input | REG_W | Source register A |
| in_src_b | input | REG_W | Source register B |
| issue | output | 1 | Candidate accepted this cycle |
| stall | output | 1 | Candidate held, bubble inserted |
| stage_occ | output | NSTAGES | Occupancy per stage, bit 0 = dependency-check stage |

## Verification
A corrupted stage entry shows up at the ports in one of two ways: a bubble count that differs from the expected wait, or an occupancy bit out of place.
- A lost or misplaced valid bit is visible on `stage_occ` in the very next cycle.
- A wrong stored class or destination changes how long the next dependent candidate waits, so it is seen within at most seven cycles of that candidate arriving.

The sweeps cover every combination of producer class, consumer class, swizzle flag and matching source. They also vary the producer-to-consumer distance, so that an off-by-one in the stage index shows as an extra or a missing bubble.

// File: rtl/vpi_pkg.sv
package vpi_pkg;

  typedef enum logic [1:0] {
    CLS_SP  = 2'd0,
    CLS_DP  = 2'd1,
    CLS_TR  = 2'd2,
    CLS_RSV = 2'd3
  } vclass_e;

  // Wait cycles by the stage the consumer needs the data in
  localparam int PEN_NEAR = 3;   // forward into first arithmetic stage
  localparam int PEN_VC1  = 5;   // forward into first shuffle stage
  localparam int PEN_WB   = 7;   // wait for write-back, no cross-family bypass

  function automatic int need_cycles(vclass_e prod, vclass_e cons,
                                     logic swz_b, logic hit_a, logic hit_b);
    int n;
    n = 0;
    if (hit_a || hit_b) begin
      if ((prod == CLS_DP) != (cons == CLS_DP))
        n = PEN_WB;
      else if (cons == CLS_TR || (swz_b && hit_b))
        n = PEN_VC1;
      else
        n = PEN_NEAR;
    end
    return n;
  endfunction

endpackage

// File: rtl/vpi_stage_track.sv
module vpi_stage_track
  import vpi_pkg::*;
#(
  parameter int NSTAGES = 8,
  parameter int REG_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [REG_W-1:0] push_dst,
  input  vclass_e          push_cls,
  output logic             occ [NSTAGES],
  output logic [REG_W-1:0] dst [NSTAGES],
  output vclass_e          cls [NSTAGES]
);

  always_ff @(posedge clk) begin
    if (rst) occ[0] <= 1'b0;
    else     occ[0] <= push;
    dst[0] <= push_dst;
    cls[0] <= push_cls;
  end

  for (genvar k = 1; k < NSTAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) occ[k] <= 1'b0;
      else     occ[k] <= occ[k-1];
      dst[k] <= dst[k-1];
      cls[k] <= cls[k-1];
    end
  end

endmodule

// File: rtl/vpi_hazard_lane.sv
module vpi_hazard_lane
  import vpi_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int STAGE_IDX = 0,
  parameter int CNT_W     = 3
) (
  input  logic             occ,
  input  logic [REG_W-1:0] prod_dst,
  input  vclass_e          prod_cls,
  input  vclass_e          cand_cls,
  input  logic             cand_swz,
  input  logic [REG_W-1:0] cand_src_a,
  input  logic [REG_W-1:0] cand_src_b,
  output logic [CNT_W-1:0] wait_cyc
);

  logic hit_a, hit_b;
  int   need;

  always_comb begin
    hit_a = occ && (cand_src_a == prod_dst);
    hit_b = occ && (cand_src_b == prod_dst);
    need  = need_cycles(prod_cls, cand_cls, cand_swz, hit_a, hit_b);
    if (need > STAGE_IDX) wait_cyc = CNT_W'(need - STAGE_IDX);
    else                  wait_cyc = '0;
  end

endmodule

// File: rtl/vpi_max_reduce.sv
module vpi_max_reduce #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [W-1:0] vals [N],
  output logic [W-1:0] max_val
);

  always_comb begin
    max_val = '0;
    for (int i = 0; i < N; i++)
      if (vals[i] > max_val) max_val = vals[i];
  end

endmodule

// File: rtl/vec_issue_interlock.sv
module vec_issue_interlock
  import vpi_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NSTAGES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_class,
  input  logic               in_swz,
  input  logic [REG_W-1:0]   in_dst,
  input  logic [REG_W-1:0]   in_src_a,
  input  logic [REG_W-1:0]   in_src_b,
  output logic               issue,
  output logic               stall,
  output logic [NSTAGES-1:0] stage_occ
);

  localparam int CNT_W = $clog2(PEN_WB + 1);

  vclass_e          cand_cls;
  logic             occ  [NSTAGES];
  logic [REG_W-1:0] sdst [NSTAGES];
  vclass_e          scls [NSTAGES];
  logic [CNT_W-1:0] lane_wait [NSTAGES];
  logic [CNT_W-1:0] worst_wait;

  assign cand_cls = vclass_e'(in_class);

  vpi_stage_track #(.NSTAGES(NSTAGES), .REG_W(REG_W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .push     (issue),
    .push_dst (in_dst),
    .push_cls (cand_cls),
    .occ      (occ),
    .dst      (sdst),
    .cls      (scls)
  );

  for (genvar k = 0; k < NSTAGES; k++) begin : g_lane
    vpi_hazard_lane #(.REG_W(REG_W), .STAGE_IDX(k), .CNT_W(CNT_W)) u_lane (
      .occ        (occ[k]),
      .prod_dst   (sdst[k]),
      .prod_cls   (scls[k]),
      .cand_cls   (cand_cls),
      .cand_swz   (in_swz),
      .cand_src_a (in_src_a),
      .cand_src_b (in_src_b),
      .wait_cyc   (lane_wait[k])
    );
    assign stage_occ[k] = occ[k];
  end

  vpi_max_reduce #(.N(NSTAGES), .W(CNT_W)) u_max (
    .vals    (lane_wait),
    .max_val (worst_wait)
  );

  assign in_ready = (worst_wait == '0);
  assign issue    = in_valid && in_ready;
  assign stall    = in_valid && !in_ready;

endmodule

// File: rtl/vec_issue_interlock_chk.sv
module vec_issue_interlock_chk
  import vpi_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NSTAGES = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic [1:0]         in_class,
  input logic               in_swz,
  input logic [REG_W-1:0]   in_dst,
  input logic [REG_W-1:0]   in_src_a,
  input logic [REG_W-1:0]   in_src_b,
  input logic               issue,
  input logic               stall,
  input logic [NSTAGES-1:0] stage_occ
);

  int stall_run;
  always_ff @(posedge clk) begin
    if (rst)        stall_run <= 0;
    else if (stall) stall_run <= stall_run + 1;
    else            stall_run <= 0;
  end

  assert_reset_empty_R1: assert property (@(posedge clk)
    $past(rst) |-> (stage_occ == '0));

  assert_idle_no_stall_R2: assert property (@(posedge clk) disable iff (rst)
    (stage_occ == '0) |-> !stall);

  assert_grant_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
    issue |-> in_valid);

  assert_stall_bound_R6: assert property (@(posedge clk) disable iff (rst)
    stall_run <= PEN_WB);

  assert_enter_first_R9: assert property (@(posedge clk) disable iff (rst)
    issue |=> stage_occ[0]);

  assert_bubble_first_R9: assert property (@(posedge clk) disable iff (rst)
    !issue |=> !stage_occ[0]);

  for (genvar k = 0; k + 1 < NSTAGES; k++) begin : g_adv
    assert_advance_R9: assert property (@(posedge clk) disable iff (rst)
      stage_occ[k] |=> stage_occ[k+1]);
  end

  assert_no_grant_when_held_R10: assert property (@(posedge clk) disable iff (rst)
    !(issue && stall));

  assert_hold_payload_R10: assert property (@(posedge clk) disable iff (rst)
    stall |=> (in_valid && $stable(in_class) && $stable(in_swz) && $stable(in_dst)
               && $stable(in_src_a) && $stable(in_src_b)));

endmodule

bind vec_issue_interlock vec_issue_interlock_chk #(.REG_W(REG_W), .NSTAGES(NSTAGES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_class  (in_class),
  .in_swz    (in_swz),
  .in_dst    (in_dst),
  .in_src_a  (in_src_a),
  .in_src_b  (in_src_b),
  .issue     (issue),
  .stall     (stall),
  .stage_occ (stage_occ)
);

// File: tb/test_vec_issue_interlock.sv
`timescale 1ns/1ps
module test_vec_issue_interlock;

  localparam int REG_W = 5;
  localparam int NST   = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [1:0]       in_class = 2'd0;
  logic             in_swz = 1'b0;
  logic [REG_W-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic             issue, stall;
  logic [NST-1:0]   stage_occ;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  vec_issue_interlock #(.REG_W(REG_W), .NSTAGES(NST)) i_vec_issue_interlock (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_swz(in_swz), .in_dst(in_dst),
    .in_src_a(in_src_a), .in_src_b(in_src_b),
    .issue(issue), .stall(stall), .stage_occ(stage_occ)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Present one instruction, count the held cycles until acceptance.
  task automatic send(input logic [1:0] c, input logic s, input logic [REG_W-1:0] d,
                      input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
                      output int bubbles);
    @(negedge clk);
    in_valid = 1'b1; in_class = c; in_swz = s; in_dst = d; in_src_a = a; in_src_b = b;
    bubbles = 0;
    #1;
    while (!in_ready) begin
      bubbles++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Expected wait from the requirement table (R3..R7, R11)
  function automatic int expect_wait(int pc, int cc, bit s, bit ma, bit mb);
    if (!ma && !mb) return 0;
    if ((pc == 1) != (cc == 1)) return 7;
    if (cc == 2 || (s && mb)) return 5;
    return 3;
  endfunction

  function automatic string tag_of(int pc, int cc, bit s, bit ma, bit mb);
    if (!ma && !mb) return "R2";
    if ((pc == 1) != (cc == 1)) return "R6";
    if (cc == 2) return "R5";
    if (s && mb) return "R4";
    if (pc == 1) return "R7";
    if (s) return "R11";
    return "R3";
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int bub;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 occupancy in reset", int'(stage_occ), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 occupancy after reset", int'(stage_occ), 0);
    chk("R1 stall after reset", int'(stall), 0);

    // R2: independent back-to-back stream
    for (int i = 0; i < 6; i++) begin
      send(2'(i % 3), 1'b0, 5'(10 + i), 5'(20 + i), 5'(26 + i), bub);
      chk("R2 independent stream", bub, 0);
    end
    idle(NST + 2);

    // R9: occupancy walk of a single instruction
    send(2'd0, 1'b0, 5'd1, 5'd2, 5'd3, bub);
    for (int k = 0; k <= NST; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      chk("R9 occupancy walk", int'(stage_occ), (k < NST) ? (1 << k) : 0);
    end
    idle(2);

    // R9/R10: bubbles during a 3-cycle hold
    send(2'd0, 1'b0, 5'd4, 5'd5, 5'd6, bub);
    @(negedge clk);
    in_valid = 1'b1; in_class = 2'd0; in_swz = 1'b0;
    in_dst = 5'd7; in_src_a = 5'd4; in_src_b = 5'd8;
    for (int b = 0; b < 3; b++) begin
      #1;
      chk("R9 bubble occupancy", int'(stage_occ), 1 << b);
      chk("R10 held stall", int'(stall), 1);
      chk("R10 held ready", int'(in_ready), 0);
      @(negedge clk);
    end
    #1;
    chk("R10 released ready", int'(in_ready), 1);
    @(posedge clk);
    idle(NST + 2);

    // Sweep: producer class x consumer class x swizzle x matching sources
    for (int pc = 0; pc < 3; pc++)
      for (int cc = 0; cc < 3; cc++)
        for (int s = 0; s < 2; s++)
          for (int m = 0; m < 4; m++) begin
            bit ma, mb;
            ma = m[0];
            mb = m[1];
            send(2'(pc), 1'b0, 5'd5, 5'd30, 5'd31, bub);
            send(2'(cc), 1'(s), 5'd11, ma ? 5'd5 : 5'd7, mb ? 5'd5 : 5'd9, bub);
            chk(tag_of(pc, cc, 1'(s), ma, mb), bub, expect_wait(pc, cc, 1'(s), ma, mb));
            idle(NST + 1);
          end

    // R8: distance between producer and consumer
    for (int k = 0; k <= NST; k++) begin
      send(2'd1, 1'b0, 5'd3, 5'd30, 5'd31, bub);
      for (int f = 0; f < k; f++) begin
        send(2'd0, 1'b0, 5'(12 + f), 5'd30, 5'd31, bub);
      end
      send(2'd0, 1'b0, 5'd25, 5'd3, 5'd29, bub);
      chk("R8 distance", bub, (7 - k > 0) ? 7 - k : 0);
      idle(NST + 1);
    end

    // R8: longest wait across two producers
    send(2'd1, 1'b0, 5'd1, 5'd30, 5'd31, bub);
    send(2'd0, 1'b0, 5'd2, 5'd30, 5'd31, bub);
    send(2'd0, 1'b0, 5'd9, 5'd1, 5'd2, bub);
    chk("R8 max of producers", bub, 6);
    idle(NST + 1);
    send(2'd0, 1'b0, 5'd2, 5'd30, 5'd31, bub);
    send(2'd1, 1'b0, 5'd1, 5'd30, 5'd31, bub);
    send(2'd0, 1'b0, 5'd9, 5'd1, 5'd2, bub);
    chk("R8 max of producers reversed", bub, 7);
    idle(NST + 1);

    // R1: reset while busy clears the stages
    send(2'd1, 1'b0, 5'd1, 5'd30, 5'd31, bub);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 reset while busy", int'(stage_occ), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule